// File: doc/BRIEF.md
# Address Latch Strobe Gate

This block drives the address-latch-enable pin of a multiplexed external address/data bus. A free-running phase counter divides the oscillator clock into bus cycles of `PHASES` clocks, four by default. The strobe is high for the first clock of a bus cycle and low for the rest. Its falling edge marks the point where the multiplexed lines change from address to data.

A quiet-mode control bit reduces radiated noise. With the bit clear, the strobe pulses in every bus cycle, which gives one quarter of the crystal frequency by default. With the bit set, the strobe pulses only in bus cycles that go off chip: an external data move or an external fetch. During internal-only activity it stays low, so the external latch never opens.

The control bit and the two access indications are sampled once, on the last clock of each bus cycle. They decide whether the next cycle carries a pulse. As a result, a change of mode can never produce a shortened or split pulse.

Top module: `ale_gate`

## Requirements
- R1: While `rst_n` is low, `ale` is low. After `rst_n` is released, the first pulse appears in the clock that follows the `PHASES`-th rising edge, and further pulses follow every `PHASES` clocks.
- R2: With `quiet` held at 0, `ale` is high in exactly one clock out of every `PHASES` clocks, regardless of `xmove` and `xfetch`.
- R3: Every pulse on `ale` lasts exactly one clock.
- R4: With `quiet` at 1, a bus cycle pulses when `xmove` is 1 at its sampling edge.
- R5: With `quiet` at 1, a bus cycle pulses when `xfetch` is 1 at its sampling edge.
- R6: With `quiet` at 1 and both `xmove` and `xfetch` at 0 at the sampling edge, `ale` stays low for the whole following bus cycle.
- R7: `quiet`, `xmove` and `xfetch` are sampled only at the last rising edge of a bus cycle. Their values at the other edges have no effect on `ale`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quiet | input | 1 | Quiet-mode control; 0 after reset means continuous strobing |
| xmove | input | 1 | The coming bus cycle is an off-chip data move |
| xfetch | input | 1 | The coming bus cycle is an off-chip fetch |
| ale | output | 1 | Address latch enable pin level |

## Verification
The bench walks through every combination of `quiet`, `xmove` and `xfetch`, each held for a whole bus cycle. These combinations separate three cases: continuous mode, which must ignore the access lines; quiet mode, where each off-chip indication must reopen the strobe on its own; and quiet mode with no access, which must stay low. Directed cycles then change the inputs only at the non-sampling edges, and only at the sampling edge. This shows whether the design samples at the cycle boundary or somewhere else. A reset applied mid-run checks that the phase restarts and that the first pulse lands in the right clock.

// File: rtl/ale_gate.sv
module ale_gate #(
  parameter int PHASES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet,
  input  logic xmove,
  input  logic xfetch,
  output logic ale
);
  localparam int CW = (PHASES > 2) ? $clog2(PHASES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASES - 1);

  logic [CW-1:0] phase;
  logic          at_end;
  logic          want;

  assign at_end = (phase == LAST);
  assign want   = !quiet || xmove || xfetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      ale   <= 1'b0;
    end else begin
      phase <= at_end ? '0 : phase + 1'b1;
      ale   <= at_end && want;
    end
  end
endmodule

module ale_gate_chk #(
  parameter int PHASES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic quiet,
  input logic xmove,
  input logic xfetch,
  input logic ale
);
  localparam int CW = (PHASES > 2) ? $clog2(PHASES) : 1;
  logic [CW-1:0] k;
  logic          edge_last;

  assign edge_last = (k == CW'(PHASES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) k <= '0;
    else        k <= edge_last ? '0 : k + 1'b1;

  AST_RESET_LOW:   assert property (@(posedge clk) !rst_n |-> !ale);                                           // R1
  AST_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (k == '0));                    // R1
  AST_FREE_RUN:    assert property (@(posedge clk) disable iff (!rst_n) (edge_last && !quiet) |=> ale);        // R2
  AST_ONE_CLK:     assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);                         // R3
  AST_XMOVE:       assert property (@(posedge clk) disable iff (!rst_n) (edge_last && xmove) |=> ale);         // R4
  AST_XFETCH:      assert property (@(posedge clk) disable iff (!rst_n) (edge_last && xfetch) |=> ale);        // R5
  AST_QUIET_IDLE:  assert property (@(posedge clk) disable iff (!rst_n)
                     (edge_last && quiet && !xmove && !xfetch) |=> !ale);                                      // R6
  AST_MID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) !edge_last |=> !ale);                  // R7
endmodule

bind ale_gate ale_gate_chk #(.PHASES(PHASES)) u_chk (.*);

// File: tb/ale_gate_tb.sv
module ale_gate_tb;
  logic clk = 1'b0, rst_n = 1'b0, quiet = 1'b0, xmove = 1'b0, xfetch = 1'b0;
  wire  ale;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  ale_gate #(.PHASES(4)) u_dut (.clk(clk), .rst_n(rst_n), .quiet(quiet),
                                .xmove(xmove), .xfetch(xfetch), .ale(ale));

  // {quiet, xmove, xfetch, expected pulse}
  localparam logic [3:0] VEC [10] = '{
    4'b0001, 4'b0101, 4'b0011, 4'b0111,
    4'b1000, 4'b1101, 4'b1011, 4'b1111,
    4'b1000, 4'b0001
  };

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (ale !== exp) begin
      n_bad++;
      $display("FAIL %s: ale=%b expected %b at %0t", tag, ale, exp, $time);
    end
  endtask

  // bit p of each mask is the input value applied before edge p+1 of the bus cycle
  task automatic cyc(input logic [3:0] qm, input logic [3:0] mm, input logic [3:0] fm,
                     input logic exp, input string tag);
    for (int p = 0; p < 4; p++) begin
      quiet = qm[p]; xmove = mm[p]; xfetch = fm[p];
      @(posedge clk); @(negedge clk);
      check((p == 3) ? exp : 1'b0, tag);
    end
  endtask

  function automatic string tag_of(input logic [3:0] v);
    if (!v[3])       return "R2";
    if (v[2])        return "R4";
    if (v[1])        return "R5";
    return "R6";
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: ale=%b expected run to end", ale);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); check(1'b0, "R1 in reset");
    @(negedge clk); check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    cyc(4'h0, 4'h0, 4'h0, 1'b1, "R1 first pulse");
    cyc(4'h0, 4'h0, 4'h0, 1'b1, "R3 second period");

    foreach (VEC[i])
      cyc({4{VEC[i][3]}}, {4{VEC[i][2]}}, {4{VEC[i][1]}}, VEC[i][0], tag_of(VEC[i]));

    // R7: inputs change only away from the sampling edge
    cyc(4'b1000, 4'b0000, 4'b0000, 1'b0, "R7 quiet set only at boundary");
    cyc(4'b0111, 4'b0000, 4'b0000, 1'b1, "R7 quiet cleared only at boundary");
    cyc(4'b1111, 4'b0111, 4'b0000, 1'b0, "R7 xmove gone before boundary");
    cyc(4'b1111, 4'b0000, 4'b0111, 1'b0, "R7 xfetch gone before boundary");
    cyc(4'b1111, 4'b1000, 4'b0000, 1'b1, "R7 R4 xmove only at boundary");
    cyc(4'b1111, 4'b0000, 4'b1000, 1'b1, "R7 R5 xfetch only at boundary");

    // R1: reset mid-cycle, phase restarts
    quiet = 1'b0; xmove = 1'b0; xfetch = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); check(1'b0, "R1 reset mid-run");
    @(negedge clk); check(1'b0, "R1 reset mid-run");
    rst_n = 1'b1;
    cyc(4'h0, 4'h0, 4'h0, 1'b1, "R1 pulse after re-reset");
    cyc(4'hF, 4'h0, 4'h0, 1'b0, "R6 after re-reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule